// File: doc/BRIEF.md
# Transmit Multichannel Slot Selector

This block sits beside a serial transmitter that sends frames made of channel slots. For each slot it decides two things. The first is whether the slot is enabled, which means a word is fetched from the transmit buffer and shifted out. The second is whether an enabled slot is masked, which means the word is consumed but the data pin stays in high impedance. The resulting drive enable goes straight to the pin's tri-state control.

A channel counter tracks the current slot. It returns to zero on the frame-sync strobe and steps once per completed word. At frame sync the block also captures the selection mode, the range-select bit and the transmit and receive channel-enable vectors, so that every slot of a frame is judged with the same settings. One of the four modes derives transmit enabling from the receive channel enables, which keeps a symmetric link symmetric.

Top module: `tx_slot_selector`

## Requirements
- R1: After reset the slot index is 0, the captured mode is 00 and the slot reads enabled, unmasked and driven.
- R2: A frame-sync strobe clears the slot index to 0 on the next clock. This holds even when word-done is high in the same cycle.
- R3: With no frame sync, each word-done strobe increments the slot index by one. The index stays at the last channel (NUM_CH-1) once it gets there, and it holds whenever there is no strobe.
- R4: Mode 00 enables and unmasks every slot, whatever the enable vectors hold.
- R5: In mode 01 a slot is enabled only when its transmit-enable bit (bit index = slot index) is set. An enabled slot is unmasked.
- R6: In mode 10 every slot is enabled. A slot is masked unless its transmit-enable bit is set.
- R7: In mode 11 a slot is enabled only when its receive-enable bit is set. An enabled slot is masked unless its transmit-enable bit is also set.
- R8: With range-select 0 (32-channel range), slots at index 32 and above count as unselected in modes 01, 10 and 11. With range-select 1, all 128 enable bits apply.
- R9: The mode, range and enable inputs take effect only at frame sync. Changes between syncs leave the current slot results unchanged.
- R10: The drive enable is high exactly when the slot is enabled and unmasked. A disabled slot reports mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_mode_i | input | 2 | Selection mode, captured at frame sync |
| wide_range_i | input | 1 | 1: 128 selectable channels, 0: 32 |
| xmt_chan_en_i | input | NUM_CH | Transmit channel-enable bits, one per slot |
| rcv_chan_en_i | input | NUM_CH | Receive channel-enable bits, one per slot |
| fsync_i | input | 1 | Frame-sync strobe |
| word_done_i | input | 1 | End-of-word strobe |
| slot_idx_o | output | $clog2(NUM_CH) | Current slot index |
| slot_en_o | output | 1 | Slot is enabled (word consumed) |
| slot_mask_o | output | 1 | Enabled slot is masked (pin high-Z) |
| data_oe_o | output | 1 | Tri-state drive enable for the data pin |

## Verification
The index and the captured settings are registered, so the effect of a strobe or of a settings change sampled at a rising edge shows on every output one edge later. The enable, mask and drive outputs are combinational from that registered state and add no further delay. The bench applies inputs on the falling edge and advances its reference model at the rising edge. It then compares every output on the following falling edge, so each result is checked in the one cycle where it becomes due. Random settings change between syncs, which exercises the rule that only frame sync can alter the results.

// File: rtl/tx_slot_pkg.sv
// Package: shared types for the transmit slot selector.
// Assumes a 2-bit mode encoding that is fixed by the register field it mirrors.
package tx_slot_pkg;
    typedef enum logic [1:0] {
        SEL_ALL      = 2'b00,  // every slot on and driven
        SEL_XMT_GATE = 2'b01,  // transmit bit gates the slot
        SEL_XMT_MASK = 2'b10,  // all on, transmit bit unmasks
        SEL_SYMM     = 2'b11   // receive bit gates, transmit bit unmasks
    } sel_mode_e;
endpackage

// File: rtl/tx_slot_cfg.sv
// Module: tx_slot_cfg
// Captures mode, range and both enable vectors on frame sync and holds them
// for the whole frame. Assumes fsync_i is a single-cycle strobe.
module tx_slot_cfg
    import tx_slot_pkg::*;
#(
    parameter int NUM_CH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic [1:0]        sel_mode_i,
    input  logic              wide_range_i,
    input  logic [NUM_CH-1:0] xmt_chan_en_i,
    input  logic [NUM_CH-1:0] rcv_chan_en_i,
    output sel_mode_e         mode_q,
    output logic              wide_q,
    output logic [NUM_CH-1:0] xmt_q,
    output logic [NUM_CH-1:0] rcv_q
);
    // Load the frame settings at sync; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SEL_ALL;
            wide_q <= 1'b0;
            xmt_q  <= '0;
            rcv_q  <= '0;
        end else if (fsync_i) begin
            mode_q <= sel_mode_e'(sel_mode_i);
            wide_q <= wide_range_i;
            xmt_q  <= xmt_chan_en_i;
            rcv_q  <= rcv_chan_en_i;
        end
    end

    AST_CFG_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_i |=> $stable(mode_q) && $stable(wide_q)); // R9
    AST_CFG_HOLD_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_i |=> $stable(xmt_q) && $stable(rcv_q)); // R9
endmodule

// File: rtl/tx_slot_counter.sv
// Module: tx_slot_counter
// Slot index: cleared by frame sync, stepped by word-done and saturating at
// the last channel. Frame sync has priority over word-done.
module tx_slot_counter #(
    parameter int NUM_CH = 128,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             word_done_i,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    // Track the current slot within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (fsync_i)
            idx_q <= '0;
        else if (word_done_i && idx_q != LAST_IDX)
            idx_q <= idx_q + 1'b1;
    end

    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> idx_q == '0); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && word_done_i && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + 1'b1); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && (!word_done_i || idx_q == LAST_IDX)) |=> $stable(idx_q)); // R3
endmodule

// File: rtl/tx_slot_decide.sv
// Module: tx_slot_decide
// Combinational slot verdict from the captured settings and the slot index.
// Assumes NARROW_CH <= NUM_CH. A disabled slot reports mask 0.
module tx_slot_decide
    import tx_slot_pkg::*;
#(
    parameter int NUM_CH    = 128,
    parameter int NARROW_CH = 32,
    localparam int IDX_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_mode_e         mode_q,
    input  logic              wide_q,
    input  logic [NUM_CH-1:0] xmt_q,
    input  logic [NUM_CH-1:0] rcv_q,
    input  logic [IDX_W-1:0]  idx_q,
    output logic              slot_en,
    output logic              slot_mask
);
    logic in_range;
    logic xmt_hit;
    logic rcv_hit;

    // Range test: a compare is only needed when the narrow range is shorter.
    if (NARROW_CH >= NUM_CH) begin : g_full
        assign in_range = 1'b1;
    end else begin : g_narrow
        assign in_range = wide_q || (int'(idx_q) < NARROW_CH);
    end

    // Pick this slot's enable bits, gated by the active range.
    always_comb begin
        xmt_hit = xmt_q[idx_q] && in_range;
        rcv_hit = rcv_q[idx_q] && in_range;
    end

    // Mode table for the enable and mask verdicts.
    always_comb begin
        unique case (mode_q)
            SEL_ALL: begin
                slot_en   = 1'b1;
                slot_mask = 1'b0;
            end
            SEL_XMT_GATE: begin
                slot_en   = xmt_hit;
                slot_mask = 1'b0;
            end
            SEL_XMT_MASK: begin
                slot_en   = 1'b1;
                slot_mask = !xmt_hit;
            end
            default: begin
                slot_en   = rcv_hit;
                slot_mask = rcv_hit && !xmt_hit;
            end
        endcase
    end

    AST_MASK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        slot_mask |-> slot_en); // R10
    AST_ALL_MODE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_ALL) |-> (slot_en && !slot_mask)); // R4
    AST_MASK_MODE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEL_XMT_MASK) |-> slot_en); // R6
endmodule

// File: rtl/tx_slot_selector.sv
// Module: tx_slot_selector (top)
// Per-slot enable/mask/drive decision for a multichannel serial transmitter.
// Settings are captured at frame sync; outputs follow the registered index.
module tx_slot_selector
    import tx_slot_pkg::*;
#(
    parameter int NUM_CH    = 128,
    parameter int NARROW_CH = 32,
    localparam int IDX_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_mode_i,
    input  logic              wide_range_i,
    input  logic [NUM_CH-1:0] xmt_chan_en_i,
    input  logic [NUM_CH-1:0] rcv_chan_en_i,
    input  logic              fsync_i,
    input  logic              word_done_i,
    output logic [IDX_W-1:0]  slot_idx_o,
    output logic              slot_en_o,
    output logic              slot_mask_o,
    output logic              data_oe_o
);
    sel_mode_e         mode_q;
    logic              wide_q;
    logic [NUM_CH-1:0] xmt_q;
    logic [NUM_CH-1:0] rcv_q;
    logic [IDX_W-1:0]  idx_q;
    logic              slot_en;
    logic              slot_mask;

    tx_slot_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
        .sel_mode_i(sel_mode_i), .wide_range_i(wide_range_i),
        .xmt_chan_en_i(xmt_chan_en_i), .rcv_chan_en_i(rcv_chan_en_i),
        .mode_q(mode_q), .wide_q(wide_q), .xmt_q(xmt_q), .rcv_q(rcv_q)
    );

    tx_slot_counter #(.NUM_CH(NUM_CH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
        .word_done_i(word_done_i), .idx_q(idx_q)
    );

    tx_slot_decide #(.NUM_CH(NUM_CH), .NARROW_CH(NARROW_CH)) u_dec (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .wide_q(wide_q),
        .xmt_q(xmt_q), .rcv_q(rcv_q), .idx_q(idx_q),
        .slot_en(slot_en), .slot_mask(slot_mask)
    );

    // Drive the outputs; the pin is driven only for enabled, unmasked slots.
    always_comb begin
        slot_idx_o  = idx_q;
        slot_en_o   = slot_en;
        slot_mask_o = slot_mask;
        data_oe_o   = slot_en && !slot_mask;
    end

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> slot_idx_o == '0); // R2
    AST_OE_OFF_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_mask_o |-> !data_oe_o); // R10
endmodule

// File: tb/tx_slot_selector_tb_top.sv
// Testbench: directed corners plus seeded random traffic against a bench model.
module tx_slot_selector_tb_top;
    localparam int NUM_CH = 128;
    localparam int NARROW = 32;
    localparam int IDX_W  = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              wide = 1'b0;
    logic [NUM_CH-1:0] xv = '0;
    logic [NUM_CH-1:0] rv = '0;
    logic              fsync = 1'b0;
    logic              wdone = 1'b0;
    logic [IDX_W-1:0]  idx;
    logic              en, msk, oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench reference state
    logic [1:0]        m_mode = 2'b00;
    logic              m_wide = 1'b0;
    logic [NUM_CH-1:0] m_x = '0;
    logic [NUM_CH-1:0] m_r = '0;
    int                m_idx = 0;

    always #10 clk = ~clk;  // 50 MHz

    tx_slot_selector #(.NUM_CH(NUM_CH), .NARROW_CH(NARROW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_mode_i(mode), .wide_range_i(wide),
        .xmt_chan_en_i(xv), .rcv_chan_en_i(rv), .fsync_i(fsync),
        .word_done_i(wdone), .slot_idx_o(idx), .slot_en_o(en),
        .slot_mask_o(msk), .data_oe_o(oe)
    );

    // Expected {enable, mask} from the requirements.
    function automatic logic [1:0] exp_sel(input logic [1:0] md, input logic wd,
        input logic [NUM_CH-1:0] x, input logic [NUM_CH-1:0] r, input int i);
        logic inr, xs, rs;
        inr = wd || (i < NARROW);
        xs  = x[i] && inr;
        rs  = r[i] && inr;
        case (md)
            2'b00:   return 2'b10;
            2'b01:   return {xs, 1'b0};
            2'b10:   return {1'b1, !xs};
            default: return {rs, rs && !xs};
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare(input string sel_tag, input string idx_tag);
        logic [1:0] e;
        e = exp_sel(m_mode, m_wide, m_x, m_r, m_idx);
        check(int'(idx) == m_idx, idx_tag, "slot_idx", int'(idx), m_idx);
        check({en, msk} === e, sel_tag, "{en,mask}", int'({en, msk}), int'(e));
        check(oe === (e[1] && !e[0]), "R10", "data_oe", int'(oe), int'(e[1] && !e[0]));
    endtask

    // One clock: apply strobes at the falling edge, update model, check next fall.
    task automatic cyc(input logic fs, input logic wd, input string sel_tag);
        fsync = fs;
        wdone = wd;
        @(posedge clk);
        if (fs) begin
            m_mode = mode; m_wide = wide; m_x = xv; m_r = rv; m_idx = 0;
        end else if (wd && m_idx != NUM_CH - 1) begin
            m_idx++;
        end
        @(negedge clk);
        fsync = 1'b0;
        wdone = 1'b0;
        compare(sel_tag, fs ? "R2" : "R3");
    endtask

    function automatic logic [NUM_CH-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(idx == '0, "R1", "reset idx", int'(idx), 0);
        check(en && !msk && oe, "R1", "reset en/mask/oe", int'({en, msk, oe}), 3'b101);

        // R4: mode 00 ignores empty vectors
        mode = 2'b00; xv = '0; rv = '0;
        cyc(1, 0, "R4"); cyc(0, 1, "R4");

        // R5: mode 01, slot 0 on, slot 1 off
        mode = 2'b01; xv = '0; xv[0] = 1'b1;
        cyc(1, 0, "R5"); cyc(0, 1, "R5");
        check(!en && !msk && !oe, "R10", "disabled slot", int'({en, msk, oe}), 0);

        // R6: mode 10, slot 1 masked
        mode = 2'b10;
        cyc(1, 0, "R6"); cyc(0, 1, "R6");
        check(en && msk && !oe, "R6", "masked slot", int'({en, msk, oe}), 3'b110);

        // R7: mode 11, rx on 0,1; tx on 0 only
        mode = 2'b11; rv = '0; rv[1:0] = 2'b11; xv = '0; xv[0] = 1'b1;
        cyc(1, 0, "R7"); cyc(0, 1, "R7");
        check(en && msk, "R7", "rx-on tx-off masked", int'({en, msk}), 3);
        cyc(0, 1, "R7");
        check(!en, "R7", "rx-off disabled", int'(en), 0);

        // R8: narrow range cuts at index 32
        mode = 2'b01; wide = 1'b0; xv = '1;
        cyc(1, 0, "R8");
        for (int k = 0; k < NARROW - 1; k++) cyc(0, 1, "R8");
        check(en, "R8", "idx31 in narrow range", int'(en), 1);
        cyc(0, 1, "R8");
        check(int'(idx) == NARROW && !en, "R8", "idx32 out of narrow range", int'(en), 0);
        wide = 1'b1;
        cyc(1, 0, "R8");
        for (int k = 0; k < NARROW; k++) cyc(0, 1, "R8");
        check(en, "R8", "idx32 in wide range", int'(en), 1);

        // R3: saturation at last channel
        for (int k = 0; k < NUM_CH + 10; k++) cyc(0, 1, "R3");
        check(int'(idx) == NUM_CH - 1, "R3", "saturated idx", int'(idx), NUM_CH - 1);

        // R9: mid-frame change has no effect
        mode = 2'b01; xv = '0;
        cyc(1, 0, "R9");
        mode = 2'b00; xv = '1;
        cyc(0, 0, "R9");
        check(!en, "R9", "mid-frame settings ignored", int'(en), 0);

        // R2: sync beats word-done in the same cycle
        cyc(0, 1, "R9");
        cyc(1, 1, "R2");
        check(idx == '0, "R2", "sync priority", int'(idx), 0);

        // random traffic with settings changing between syncs
        for (int n = 0; n < 4000; n++) begin
            mode = 2'($urandom);
            wide = 1'($urandom);
            xv = rnd_vec();
            rv = rnd_vec();
            cyc(($urandom % 40) == 0, ($urandom % 4) != 0, mode_tag(m_mode));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule